// File: doc/BRIEF.md
# Audio Capture Channel Receive FIFO

This block is the receive half of one audio channel on a serial codec link. A link front end, outside the block, hands it one slot sample at a time (slot number plus a 20-bit value) and a tick at the start of every frame. The block keeps the samples from the slots chosen in its control word and packs them into 32-bit words. It queues those words in a FIFO that the host drains one word per read strobe.

Two packing modes exist. In the normal mode, each accepted sample becomes one FIFO word, either as a 16-bit or as a 20-bit right-aligned value. In the compact mode, two consecutive accepted samples share one word. The block raises three interrupts. The receive request is a level that follows the half-full mark. The overrun and inactivity-timeout requests are sticky flags that the host clears by writing ones at bit positions offset by the channel index. The inactivity timeout catches a FIFO that holds a few words but will not reach half full soon, so the host does not leave trailing data unread.

Top module: `rxf_capture`

## Requirements
- R1: After reset the FIFO is empty, the half-full, full and busy flags are low, and all three interrupt outputs are low. The control word resets to zero, so the channel is disabled.
- R2: Control word layout. Bit 0 enables the channel. Bit 1 enables the FIFO. Bit 2 selects compact mode. Bits 3 to 12 accept slots 3 to 12, with slot n at bit n. Bit 13 selects 20-bit samples in normal mode. Bits 28:17 hold the timeout in frames.
- R3: In normal mode with bit 13 low, an accepted sample d becomes the word {16'h0, d[19:4]}. With bit 13 high it becomes {12'h0, d[19:0]}.
- R4: A sample is accepted only when the channel is enabled, its slot lies in 3..12, and that slot's bit is set. Any other sample leaves the FIFO unchanged.
- R5: In compact mode, the first accepted sample supplies bits 15:0 and the second supplies bits 31:16, each taken as d[19:4]. The busy flag is high while a first half waits for its partner.
- R6: Words leave in the order they were written. A read strobe removes the head word. A read strobe on an empty FIFO has no effect.
- R7: The half-full flag and the receive interrupt are high while the FIFO holds at least DEPTH/2 words. The full flag is high at DEPTH words.
- R8: A word that arrives while the FIFO is full, with no read in the same cycle, is dropped and sets the sticky overrun interrupt. The stored words are kept.
- R9: Let T be the nonzero timeout value. The timeout interrupt sets on the T-th frame tick during which the FIFO stays non-empty and below half full with no write and no read. Any write or read restarts the count. A value of 0 disables the timeout.
- R10: A write to the clear port with bit CHAN_IDX set clears the overrun interrupt. Bit CHAN_IDX+4 clears the timeout interrupt. Other bits have no effect.
- R11: With the FIFO enable bit low, the queue holds a single word. Full and half-full are both high at one word, and a second word overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Writes ctrl_wdata into the control word |
| ctrl_wdata | input | 32 | New control word |
| clr_we | input | 1 | Write strobe of the interrupt clear port |
| clr_wdata | input | 8 | Write-one-to-clear bits |
| frame_stb | input | 1 | One pulse per link frame |
| slot_stb | input | 1 | A slot sample is present |
| slot_id | input | 4 | Slot number of the sample |
| slot_data | input | 20 | Slot sample value |
| rd_stb | input | 1 | Host read of the data word |
| rd_data | output | 32 | Head word of the FIFO |
| st_empty | output | 1 | FIFO empty |
| st_half | output | 1 | FIFO at or above half |
| st_full | output | 1 | FIFO full |
| st_busy | output | 1 | Compact half-word pending |
| irq_rx | output | 1 | Receive request (half-full level) |
| irq_ovr | output | 1 | Sticky overrun |
| irq_tmo | output | 1 | Sticky inactivity timeout |

## Verification
Single samples are sent under a range of control words. Each one either enters the FIFO or is refused, depending on the enable bit, the slot mask, slots outside 3..12 and the sample size, and the stored word shows which packing was used. A pair of samples in compact mode shows the half order and the busy window. A fill past DEPTH shows where the half and full thresholds sit, and that an overrun keeps the old contents. A timeout run with a write in the middle shows that the frame count restarts. Writes of wrong clear bits confirm that only the channel's own bits act.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int SLOT_W   = 20;
  localparam int TMO_W    = 12;
  localparam int SLOT_LO  = 3;
  localparam int SLOT_HI  = 12;
  localparam int NSLOT    = SLOT_HI - SLOT_LO + 1;

  typedef struct packed {
    logic [TMO_W-1:0] tmo;
    logic             size20;
    logic [NSLOT-1:0] slot_mask;
    logic             compact;
    logic             fifo_en;
    logic             en;
  } rx_ctrl_t;

  function automatic rx_ctrl_t fn_decode(input logic [31:0] w);
    rx_ctrl_t c;
    c.en        = w[0];
    c.fifo_en   = w[1];
    c.compact   = w[2];
    c.slot_mask = w[SLOT_HI:SLOT_LO];
    c.size20    = w[13];
    c.tmo       = w[28:17];
    return c;
  endfunction

  function automatic logic fn_slot_hit(input logic [NSLOT-1:0] mask,
                                       input logic [3:0] id);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (id == 4'(i + SLOT_LO)) hit = mask[i];
    return hit;
  endfunction

  function automatic logic [15:0] fn_top16(input logic [SLOT_W-1:0] d);
    return d[SLOT_W-1:SLOT_W-16];
  endfunction

  function automatic logic [31:0] fn_norm_word(input logic [SLOT_W-1:0] d,
                                               input logic size20);
    return size20 ? {{(32-SLOT_W){1'b0}}, d} : {16'h0, fn_top16(d)};
  endfunction

endpackage

// File: rtl/rxf_slot_packer.sv
module rxf_slot_packer
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rx_ctrl_t          cfg,
  input  logic              slot_stb,
  input  logic [3:0]        slot_id,
  input  logic [SLOT_W-1:0] slot_data,
  output logic              push_req,
  output logic [31:0]       push_word,
  output logic              pend
);

  logic        accept;
  logic [15:0] half_q;

  assign accept   = cfg.en && slot_stb && fn_slot_hit(cfg.slot_mask, slot_id);
  assign push_req = accept && (!cfg.compact || pend);

  always_comb begin
    if (cfg.compact) push_word = {fn_top16(slot_data), half_q};
    else             push_word = fn_norm_word(slot_data, cfg.size20);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      half_q <= '0;
    end else if (!cfg.en || !cfg.compact) begin
      pend <= 1'b0;
    end else if (accept) begin
      if (!pend) begin
        pend   <= 1'b1;
        half_q <= fn_top16(slot_data);
      end else begin
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     deep,
  input  logic                     push,
  input  logic [31:0]              wdata,
  input  logic                     pop_req,
  output logic [31:0]              rdata,
  output logic                     empty,
  output logic                     half,
  output logic                     full,
  output logic                     push_ok,
  output logic                     pop_ok,
  output logic [$clog2(DEPTH):0]   count
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LIM_DEEP  = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_DEEP = (AW+1)'(DEPTH / 2);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   lim, half_lvl;

  assign lim      = deep ? LIM_DEEP  : (AW+1)'(1);
  assign half_lvl = deep ? HALF_DEEP : (AW+1)'(1);
  assign empty    = (count == '0);
  assign full     = (count >= lim);
  assign half     = (count >= half_lvl);
  assign pop_ok   = pop_req && !empty;
  assign push_ok  = push && (!full || pop_ok);
  assign rdata    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             activity,
  input  logic             frame_stb,
  input  logic [TMO_W-1:0] tmo_val,
  output logic             hit
);

  logic [TMO_W-1:0] cnt;

  assign hit = armed && !activity && frame_stb && (tmo_val != '0) &&
               (cnt == tmo_val - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (activity || !armed)    cnt <= '0;
    else if (frame_stb && cnt != tmo_val) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int CHAN_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        clr_we,
  input  logic [7:0]  clr_wdata,
  input  logic        frame_stb,
  input  logic        slot_stb,
  input  logic [3:0]  slot_id,
  input  logic [19:0] slot_data,
  input  logic        rd_stb,
  output logic [31:0] rd_data,
  output logic        st_empty,
  output logic        st_half,
  output logic        st_full,
  output logic        st_busy,
  output logic        irq_rx,
  output logic        irq_ovr,
  output logic        irq_tmo
);

  localparam int CW = $clog2(DEPTH) + 1;

  logic [31:0] ctrl_q;
  rx_ctrl_t    cfg;
  logic        push_req, push_ok, pop_ok, tmo_hit, ovr_ev;
  logic        clr_ovr, clr_tmo;
  logic [31:0] push_word;
  logic [CW-1:0] count;

  assign cfg = fn_decode(ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  rxf_slot_packer u_pack (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .slot_stb(slot_stb), .slot_id(slot_id), .slot_data(slot_data),
    .push_req(push_req), .push_word(push_word), .pend(st_busy)
  );

  rxf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .deep(cfg.fifo_en),
    .push(push_req), .wdata(push_word), .pop_req(rd_stb),
    .rdata(rd_data), .empty(st_empty), .half(st_half), .full(st_full),
    .push_ok(push_ok), .pop_ok(pop_ok), .count(count)
  );

  rxf_timeout u_tmo (
    .clk(clk), .rst_n(rst_n),
    .armed(!st_empty && !st_half), .activity(push_ok || pop_ok),
    .frame_stb(frame_stb), .tmo_val(cfg.tmo), .hit(tmo_hit)
  );

  assign ovr_ev  = push_req && !push_ok;
  assign clr_ovr = clr_we && clr_wdata[CHAN_IDX];
  assign clr_tmo = clr_we && clr_wdata[CHAN_IDX + 4];
  assign irq_rx  = st_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ovr <= 1'b0;
      irq_tmo <= 1'b0;
    end else begin
      irq_ovr <= (irq_ovr && !clr_ovr) || ovr_ev;
      irq_tmo <= (irq_tmo && !clr_tmo) || tmo_hit;
    end
  end

endmodule

// File: rtl/rxf_capture_chk.sv
module rxf_capture_chk #(
  parameter int DEPTH    = 8,
  parameter int CHAN_IDX = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   push_req,
  input logic                   push_ok,
  input logic                   pop_ok,
  input logic                   st_empty,
  input logic                   st_full,
  input logic                   st_busy,
  input logic                   compact_on,
  input logic                   irq_ovr,
  input logic                   irq_tmo,
  input logic                   clr_we,
  input logic [7:0]             clr_wdata,
  input logic [$clog2(DEPTH):0] count
);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r7_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_empty && st_full));

  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> !st_empty);

  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && st_full && !pop_ok) |-> !push_ok);

  a_r8_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && st_full && !pop_ok) |=> irq_ovr);

  a_r9_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tmo) |-> $past(!st_empty));

  a_r10_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_wdata[CHAN_IDX] && !(push_req && st_full && !pop_ok)) |=> !irq_ovr);

  a_r5_busy_compact: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |-> compact_on);

endmodule

bind rxf_capture rxf_capture_chk #(.DEPTH(DEPTH), .CHAN_IDX(CHAN_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_ok(push_ok),
  .pop_ok(pop_ok), .st_empty(st_empty), .st_full(st_full), .st_busy(st_busy),
  .compact_on(cfg.compact), .irq_ovr(irq_ovr), .irq_tmo(irq_tmo),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .count(count)
);

// File: tb/rxf_capture_test.sv
module rxf_capture_test;

  localparam int DEPTH = 8;
  localparam int CHAN  = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        clr_we = 1'b0;
  logic [7:0]  clr_wdata = '0;
  logic        frame_stb = 1'b0;
  logic        slot_stb = 1'b0;
  logic [3:0]  slot_id = '0;
  logic [19:0] slot_data = '0;
  logic        rd_stb = 1'b0;
  logic [31:0] rd_data;
  logic        st_empty, st_half, st_full, st_busy;
  logic        irq_rx, irq_ovr, irq_tmo;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rxf_capture #(.DEPTH(DEPTH), .CHAN_IDX(CHAN)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata), .frame_stb(frame_stb),
    .slot_stb(slot_stb), .slot_id(slot_id), .slot_data(slot_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .st_empty(st_empty),
    .st_half(st_half), .st_full(st_full), .st_busy(st_busy),
    .irq_rx(irq_rx), .irq_ovr(irq_ovr), .irq_tmo(irq_tmo)
  );

  // vector: ctrl[88:57] id[56:53] data[52:33] push[32] word[31:0]
  localparam int NV = 7;
  localparam logic [88:0] VEC [NV] = '{
    {32'h0000_000B, 4'd3,  20'hABCDE, 1'b1, 32'h0000_ABCD},
    {32'h0000_200B, 4'd3,  20'hABCDE, 1'b1, 32'h000A_BCDE},
    {32'h0000_000B, 4'd4,  20'hABCDE, 1'b0, 32'h0},
    {32'h0000_1003, 4'd12, 20'h55AA5, 1'b1, 32'h0000_55AA},
    {32'h0000_000A, 4'd3,  20'h12345, 1'b0, 32'h0},
    {32'h0000_1FFB, 4'd2,  20'h12345, 1'b0, 32'h0},
    {32'h0000_3FFB, 4'd7,  20'h00001, 1'b1, 32'h0000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic send(input logic [3:0] id, input logic [19:0] d);
    @(negedge clk);
    slot_stb = 1'b1; slot_id = id; slot_data = d;
    @(negedge clk);
    slot_stb = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic clear(input logic [7:0] v);
    @(negedge clk);
    clr_we = 1'b1; clr_wdata = v;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 empty", 32'(st_empty), 32'd1);
    chk("R1 flags", {28'h0, st_half, st_full, st_busy, irq_rx}, 32'h0);
    chk("R1 irqs", {30'h0, irq_ovr, irq_tmo}, 32'h0);

    // R2/R3/R4 table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      set_ctrl(VEC[i][88:57]);
      send(VEC[i][56:53], VEC[i][52:33]);
      chk("R4 accept", 32'(!st_empty), 32'(VEC[i][32]));
      if (VEC[i][32]) chk("R3 word", rd_data, VEC[i][31:0]);
    end

    // R5 compact packing
    do_reset();
    set_ctrl(32'h0000_001F);
    send(4'd3, 20'hABCDE);
    chk("R5 busy", 32'(st_busy), 32'd1);
    chk("R5 no word yet", 32'(st_empty), 32'd1);
    send(4'd4, 20'h12345);
    chk("R5 busy done", 32'(st_busy), 32'd0);
    chk("R5 pair word", rd_data, 32'h1234_ABCD);

    // R6/R7/R8 fill, overrun, order
    do_reset();
    set_ctrl(32'h0000_000B);
    pop();
    chk("R6 pop empty", 32'(st_empty), 32'd1);
    for (int k = 1; k <= 3; k++) send(4'd3, 20'(k << 4));
    chk("R7 below half", {30'h0, st_half, irq_rx}, 32'h0);
    send(4'd3, 20'(4 << 4));
    chk("R7 half", {30'h0, st_half, irq_rx}, 32'h3);
    for (int k = 5; k <= DEPTH; k++) send(4'd3, 20'(k << 4));
    chk("R7 full", 32'(st_full), 32'd1);
    chk("R8 no ovr yet", 32'(irq_ovr), 32'd0);
    send(4'd3, 20'h0FFF0);
    chk("R8 ovr", 32'(irq_ovr), 32'd1);
    chk("R6 head kept", rd_data, 32'd1);
    pop();
    chk("R6 order", rd_data, 32'd2);
    chk("R7 not full", 32'(st_full), 32'd0);
    clear(8'h02);
    chk("R10 wrong bit", 32'(irq_ovr), 32'd1);
    clear(8'(1 << CHAN));
    chk("R10 ovr cleared", 32'(irq_ovr), 32'd0);

    // R9 timeout with restart, R10 clear
    do_reset();
    set_ctrl(32'h0006_000B);
    send(4'd3, 20'h00010);
    frame(); frame();
    chk("R9 early", 32'(irq_tmo), 32'd0);
    send(4'd3, 20'h00020);
    frame(); frame();
    chk("R9 restarted", 32'(irq_tmo), 32'd0);
    frame();
    chk("R9 fired", 32'(irq_tmo), 32'd1);
    clear(8'(1 << CHAN));
    chk("R10 tmo kept", 32'(irq_tmo), 32'd1);
    clear(8'(1 << (CHAN + 4)));
    chk("R10 tmo cleared", 32'(irq_tmo), 32'd0);

    // R9 zero disables
    do_reset();
    set_ctrl(32'h0000_000B);
    send(4'd3, 20'h00010);
    for (int k = 0; k < 5; k++) frame();
    chk("R9 disabled", 32'(irq_tmo), 32'd0);

    // R11 single-word mode
    do_reset();
    set_ctrl(32'h0000_0009);
    send(4'd3, 20'h11110);
    chk("R11 full at one", {30'h0, st_full, st_half}, 32'h3);
    send(4'd3, 20'h22220);
    chk("R11 ovr", 32'(irq_ovr), 32'd1);
    chk("R11 head", rd_data, 32'h0000_1111);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule